// File: doc/BRIEF.md
# Random-Access Pixel Read Port

After the capture path has written a frame into the frame memory, this block lets a slow host fetch any byte of any pixel, one request at a time and at whatever pace it likes. The host places a column, a row and a byte index on its inputs and pulses `req`. The block turns the coordinate into a linear memory address and drives that address onto the shared memory address bus. It then returns the fetched byte on a bidirectional host data bus.

The image width is configured in units of four pixels. The pixel size in bytes is a separate configuration value. Both are sampled with each request. The memory address bus is shared with the capture writer. The read side owns it only while a finished frame is present and no capture is running. At all other times the writer's address passes through unchanged, and the host data bus floats.

The address is formed over two registered clock stages, and the byte is registered in a third stage. This gives every request a fixed latency and allows one request per clock.

Top module: `pix_read_port`

## Requirements
- R1: The host data bus is 10 bits wide. When the block drives it, bits 7:0 carry the memory byte and bits 9:8 are zero.
- R2: For a request accepted at rising edge k, `mem_addr` holds bpp × (col + 4·cfg_wq·row) + byte_idx after edge k+1. All five operands are sampled at edge k.
- R3: With a pixel size above one byte, successive byte_idx values address successive bytes of the same pixel.
- R4: The address is the low 19 bits of the full product-and-sum; higher bits are dropped.
- R5: `rd_valid` is high for exactly one cycle, after edge k+2. In that cycle `host_data` carries the memory byte stored at the address from R2.
- R6: `out_of_range` is high together with `rd_valid` when col ≥ 4·cfg_wq. Otherwise it is low.
- R7: The read path is enabled only while `frame_done`=1 and `capture_busy`=0. Outside that window, `mem_addr` equals `wr_addr` and `host_data` is high impedance.
- R8: A request made while the read path is disabled is dropped and never produces `rd_valid`.
- R9: Requests on consecutive cycles are all served, each with the latency given in R2 and R5.
- R10: During and right after reset, `rd_valid` and `out_of_range` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | A complete frame is held in memory |
| capture_busy | input | 1 | Capture writer is active |
| cfg_wq | input | 8 | Image width divided by four |
| cfg_bpp | input | 8 | Bytes per pixel |
| req | input | 1 | Read request strobe |
| col | input | 10 | Pixel column |
| row | input | 9 | Pixel row |
| byte_idx | input | 2 | Byte within the pixel |
| wr_addr | input | 19 | Capture writer address |
| mem_addr | output | 19 | Frame memory address |
| mem_rdata | input | 8 | Frame memory read data (combinational) |
| host_data | inout | 10 | Host data bus, tristate |
| rd_valid | output | 1 | Returned byte is valid this cycle |
| out_of_range | output | 1 | Column of the returned byte exceeded the width |

## Verification
Take a request sampled at rising edge k. Its address is due on `mem_addr` after edge k+1. Its byte, `rd_valid` and `out_of_range` are due after edge k+2. The bench drives each request on a falling edge. It reads the address on the second falling edge after that and the data on the third, and it checks that `rd_valid` is low on the falling edges either side. In streamed tests the expected address and byte are held in small arrays, and each is compared two or three falling edges after its request. Disabled-path behaviour is checked within the same windows, plus a few spare cycles in which no `rd_valid` may appear.

// File: rtl/pix_rd_pkg.sv
package pix_rd_pkg;

    parameter int COL_W  = 10;   // column coordinate
    parameter int ROW_W  = 9;    // row coordinate
    parameter int IDX_W  = 2;    // byte within pixel
    parameter int WQ_W   = 8;    // width in units of four pixels
    parameter int BPP_W  = 8;    // bytes per pixel
    parameter int ADDR_W = 19;   // frame memory address
    parameter int MEM_W  = 8;    // memory data width
    parameter int HOST_W = 10;   // host data bus width

    localparam int WFULL_W = WQ_W + 2;

    // stage 1: row-major pixel index, still in pixel units
    typedef struct packed {
        logic              vld;
        logic              oor;
        logic [ADDR_W-1:0] lin;
        logic [BPP_W-1:0]  bpp;
        logic [IDX_W-1:0]  idx;
    } s1_t;

    // stage 2: byte address
    typedef struct packed {
        logic              vld;
        logic              oor;
        logic [ADDR_W-1:0] addr;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } calc_t;

    // returned-byte register
    typedef struct packed {
        logic             vld;
        logic             oor;
        logic [MEM_W-1:0] data;
    } ret_t;

endpackage

// File: rtl/pix_addr_calc.sv
module pix_addr_calc
    import pix_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WQ_W-1:0]   wq,
    input  logic [BPP_W-1:0]  bpp,
    output logic              s2_vld,
    output logic              s2_oor,
    output logic [ADDR_W-1:0] s2_addr
);

    calc_t calc_d, calc_q;

    logic [ADDR_W-1:0] width_px;
    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] byte_base;

    always_comb begin
        calc_d = calc_q;

        // stage 1: width * row + column (modulo the address space)
        width_px  = ADDR_W'({wq, 2'b00});
        row_base  = width_px * ADDR_W'(row);
        calc_d.s1.vld = accept;
        if (accept) begin
            calc_d.s1.lin = row_base + ADDR_W'(col);
            calc_d.s1.oor = (ADDR_W'(col) >= width_px);
            calc_d.s1.bpp = bpp;
            calc_d.s1.idx = idx;
        end

        // stage 2: scale by pixel size and add byte offset
        byte_base = ADDR_W'(calc_q.s1.bpp) * calc_q.s1.lin;
        calc_d.s2.vld = calc_q.s1.vld;
        if (calc_q.s1.vld) begin
            calc_d.s2.oor  = calc_q.s1.oor;
            calc_d.s2.addr = byte_base + ADDR_W'(calc_q.s1.idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) calc_q <= '0;
        else        calc_q <= calc_d;
    end

    assign s2_vld  = calc_q.s2.vld;
    assign s2_oor  = calc_q.s2.oor;
    assign s2_addr = calc_q.s2.addr;

endmodule

// File: rtl/pix_addr_mux.sv
module pix_addr_mux
    import pix_rd_pkg::*;
(
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] mem_addr
);

    always_comb begin
        if (rd_sel) mem_addr = rd_addr;
        else        mem_addr = wr_addr;
    end

endmodule

// File: rtl/pix_data_ret.sv
module pix_data_ret
    import pix_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             s2_vld,
    input  logic             s2_oor,
    input  logic [MEM_W-1:0] mem_rdata,
    output logic             ret_vld,
    output logic             ret_oor,
    output logic [MEM_W-1:0] ret_data
);

    ret_t ret_d, ret_q;

    always_comb begin
        ret_d     = ret_q;
        ret_d.vld = s2_vld & rd_en;
        if (s2_vld & rd_en) begin
            ret_d.data = mem_rdata;
            ret_d.oor  = s2_oor;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ret_q <= '0;
        else        ret_q <= ret_d;
    end

    assign ret_vld  = ret_q.vld & rd_en;
    assign ret_oor  = ret_q.vld & ret_q.oor & rd_en;
    assign ret_data = ret_q.data;

endmodule

// File: rtl/pix_read_port.sv
module pix_read_port
    import pix_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              capture_busy,
    input  logic [WQ_W-1:0]   cfg_wq,
    input  logic [BPP_W-1:0]  cfg_bpp,
    input  logic              req,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [MEM_W-1:0]  mem_rdata,
    inout  wire  [HOST_W-1:0] host_data,
    output logic              rd_valid,
    output logic              out_of_range
);

    logic              rd_en;
    logic              accept;
    logic              s2_vld;
    logic              s2_oor;
    logic [ADDR_W-1:0] s2_addr;
    logic [MEM_W-1:0]  ret_data;

    assign rd_en  = frame_done & ~capture_busy;
    assign accept = req & rd_en;

    pix_addr_calc u_calc (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .col     (col),
        .row     (row),
        .idx     (byte_idx),
        .wq      (cfg_wq),
        .bpp     (cfg_bpp),
        .s2_vld  (s2_vld),
        .s2_oor  (s2_oor),
        .s2_addr (s2_addr)
    );

    pix_addr_mux u_mux (
        .rd_sel   (rd_en),
        .rd_addr  (s2_addr),
        .wr_addr  (wr_addr),
        .mem_addr (mem_addr)
    );

    pix_data_ret u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .s2_vld    (s2_vld),
        .s2_oor    (s2_oor),
        .mem_rdata (mem_rdata),
        .ret_vld   (rd_valid),
        .ret_oor   (out_of_range),
        .ret_data  (ret_data)
    );

    // pad drivers: low bits carry the byte, upper bits are zero-filled
    for (genvar gi = 0; gi < HOST_W; gi++) begin : g_pad
        if (gi < MEM_W) begin : g_dat
            assign host_data[gi] = rd_en ? ret_data[gi] : 1'bz;
        end else begin : g_zero
            assign host_data[gi] = rd_en ? 1'b0 : 1'bz;
        end
    end

endmodule

// File: rtl/pix_read_port_chk.sv
module pix_read_port_chk
    import pix_rd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic              capture_busy,
    input logic [WQ_W-1:0]   cfg_wq,
    input logic [BPP_W-1:0]  cfg_bpp,
    input logic              req,
    input logic [COL_W-1:0]  col,
    input logic [ROW_W-1:0]  row,
    input logic [IDX_W-1:0]  byte_idx,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [HOST_W-1:0] host_data,
    input logic              rd_valid,
    input logic              out_of_range
);

    function automatic logic [ADDR_W-1:0] ref_addr(
        input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r,
        input logic [IDX_W-1:0] i, input logic [WQ_W-1:0] w,
        input logic [BPP_W-1:0] b);
        return ADDR_W'(32'(b) * (32'(c) + 32'({w, 2'b00}) * 32'(r)) + 32'(i));
    endfunction

    // R2 R4: address two edges after an accepted request
    p_addr_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req, 2) && $past(frame_done && !capture_busy, 2) && frame_done && !capture_busy)
        |-> mem_addr == ref_addr($past(col, 2), $past(row, 2), $past(byte_idx, 2),
                                 $past(cfg_wq, 2), $past(cfg_bpp, 2)));

    // R5 R8: valid only after an accepted request three edges back
    p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req && frame_done && !capture_busy, 3));

    // R6: range flag tracks the column of that request
    p_range_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (out_of_range == ($past(col, 3) >= COL_W'({$past(cfg_wq, 3), 2'b00}))));

    // R7: writer owns the address bus when reading is disabled
    p_write_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && !capture_busy) |-> mem_addr == wr_addr);

    // R1: upper host bits zero while a byte is returned
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> host_data[HOST_W-1:MEM_W] == '0);

endmodule

bind pix_read_port pix_read_port_chk u_chk (.*);

// File: tb/sim_pix_read_port.sv
`timescale 1ns/1ps
module sim_pix_read_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done = 1'b0;
    logic        capture_busy = 1'b0;
    logic [7:0]  cfg_wq = '0;
    logic [7:0]  cfg_bpp = '0;
    logic        req = 1'b0;
    logic [9:0]  col = '0;
    logic [8:0]  row = '0;
    logic [1:0]  byte_idx = '0;
    logic [18:0] wr_addr = '0;
    logic [18:0] mem_addr;
    logic [7:0]  mem_rdata;
    wire  [9:0]  host_data;
    logic        rd_valid;
    logic        out_of_range;
    logic        tb_drv = 1'b0;
    logic [9:0]  tb_pat = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'd0};
    endfunction

    assign mem_rdata = mem_fn(mem_addr);
    assign host_data = tb_drv ? tb_pat : 10'bz;

    pix_read_port u0 (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .capture_busy(capture_busy),
        .cfg_wq(cfg_wq), .cfg_bpp(cfg_bpp), .req(req), .col(col), .row(row),
        .byte_idx(byte_idx), .wr_addr(wr_addr), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .host_data(host_data), .rd_valid(rd_valid),
        .out_of_range(out_of_range)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [18:0] exp_addr(input int c, input int r, input int b);
        int unsigned p;
        p = int'(cfg_bpp) * (c + 4 * int'(cfg_wq) * r) + b;
        return p[18:0];
    endfunction

    task automatic single_req(input int c, input int r, input int b, input bit exp_oor);
        logic [18:0] ea;
        @(negedge clk);
        col = 10'(c); row = 9'(r); byte_idx = 2'(b); req = 1'b1;
        ea = exp_addr(c, r, b);
        @(negedge clk);
        req = 1'b0;
        check("R5 early valid", 32'(rd_valid), 0);
        @(negedge clk);
        check("R2 address", 32'(mem_addr), 32'(ea));
        check("R5 valid before latency", 32'(rd_valid), 0);
        @(negedge clk);
        check("R5 valid", 32'(rd_valid), 1);
        check("R1 host byte", 32'(host_data), 32'({2'b00, mem_fn(ea)}));
        check("R6 range flag", 32'(out_of_range), 32'(exp_oor));
        @(negedge clk);
        check("R5 valid one cycle", 32'(rd_valid), 0);
    endtask

    task automatic t_reset;
        wr_addr = 19'h1234;
        repeat (3) @(negedge clk);
        check("R10 valid in reset", 32'(rd_valid), 0);
        check("R10 flag in reset", 32'(out_of_range), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after reset", 32'(rd_valid), 0);
        check("R7 writer address", 32'(mem_addr), 32'h1234);
    endtask

    task automatic t_bpp1;
        frame_done = 1'b1; cfg_wq = 8'd40; cfg_bpp = 8'd1;
        single_req(0, 0, 0, 1'b0);
        single_req(159, 119, 0, 1'b0);
        single_req(17, 3, 0, 1'b0);
    endtask

    task automatic t_multi;
        cfg_bpp = 8'd2;
        single_req(5, 2, 0, 1'b0);
        single_req(5, 2, 1, 1'b0);   // R3 next byte of same pixel
        cfg_bpp = 8'd3;
        single_req(9, 7, 2, 1'b0);   // R3 third byte
    endtask

    task automatic t_range;
        cfg_bpp = 8'd1; cfg_wq = 8'd40;
        single_req(160, 1, 0, 1'b1); // R6 first column past width
        single_req(159, 1, 0, 1'b0);
        single_req(1023, 0, 0, 1'b1);
    endtask

    task automatic t_trunc;
        cfg_wq = 8'd255; cfg_bpp = 8'd200;
        single_req(1000, 511, 3, 1'b0); // R4 wraps above 19 bits
        cfg_bpp = 8'd255;
        single_req(1019, 500, 1, 1'b0);
    endtask

    task automatic t_gate;
        cfg_wq = 8'd40; cfg_bpp = 8'd1;
        wr_addr = 19'h5A5A5;
        capture_busy = 1'b1;
        @(negedge clk);
        col = 10'd3; row = 9'd3; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check("R7 writer address while capturing", 32'(mem_addr), 32'h5A5A5);
        tb_drv = 1'b1; tb_pat = 10'h2C3;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 no valid while disabled", 32'(rd_valid), 0);
        end
        check("R7 bus floats while capturing", 32'(host_data), 32'h2C3);
        tb_drv = 1'b0;
        capture_busy = 1'b0; frame_done = 1'b0;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        tb_drv = 1'b1; tb_pat = 10'h11D;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 no valid without frame", 32'(rd_valid), 0);
        end
        check("R7 bus floats without frame", 32'(host_data), 32'h11D);
        check("R7 writer address without frame", 32'(mem_addr), 32'h5A5A5);
        tb_drv = 1'b0;
        frame_done = 1'b1;
        single_req(12, 4, 0, 1'b0);
    endtask

    task automatic t_stream;
        logic [18:0] ea [8];
        cfg_wq = 8'd20; cfg_bpp = 8'd2;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (t >= 2 && t < 10) check("R9 streamed address", 32'(mem_addr), 32'(ea[t-2]));
            if (t >= 3 && t < 11) begin
                check("R9 streamed valid", 32'(rd_valid), 1);
                check("R9 streamed byte", 32'(host_data), 32'({2'b00, mem_fn(ea[t-3])}));
            end
            if (t == 11) check("R9 stream ends", 32'(rd_valid), 0);
            if (t < 8) begin
                col = 10'(7 * t + 1); row = 9'(3 * t); byte_idx = 2'(t % 2); req = 1'b1;
                ea[t] = exp_addr(7 * t + 1, 3 * t, t % 2);
            end else begin
                req = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_bpp1;
        t_multi;
        t_range;
        t_trunc;
        t_gate;
        t_stream;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule